// File: doc/BRIEF.md
# Nibble Handshake Subprocessor Bus Master

This block lets a host move bytes to and from an I/O subprocessor over a 4-bit data path. It uses a chip-select line, a read/write line and an acknowledge input. The host issues a request with a register address, a direction and (for writes) a byte. The master puts the address on the nibble bus, raises chip select and sets the direction line. It then waits for the subprocessor to raise acknowledge. After that, no further handshake takes place. Each half of the byte is driven or sampled at a fixed clock offset counted from the acknowledge rising edge, high half first.

Acknowledge passes through two synchronizer flops before edge detection. Offset k therefore takes effect on the (k+4)-th rising clock edge after acknowledge goes high at the pins. A read also turns the nibble bus around: the output enable drops so the subprocessor can drive the bus, and it comes back once the byte has been taken.

A separate presence-detect sequence checks that a subprocessor is attached. It addresses register 3 for a write and waits for acknowledge to rise and then fall. Both waits share one poll counter, and if the counter runs out the master reports an error.

Top module: `nib_link_master`

## Requirements
- R1: After reset, chip select is low, the direction line is high (read), the nibble output enable is high, the nibble output is 0, and done and error are low.
- R2: A request accepted while idle shows, on the next clock, chip select high, the direction line high for a read or low for a write, and the 4-bit register address on the nibble output. These values hold until acknowledge is seen.
- R3: On a write, the high half of the write byte (bits 7:4) appears on the nibble output at offset 4, and chip select falls at offset 5.
- R4: On a write, the low half (bits 3:0) replaces it at offset 9. Done pulses high at the same offset with error low.
- R5: On a read, the nibble output enable falls at offset 4, and chip select falls at offset 5.
- R6: On a read, the nibble input is sampled at offset 10 as the high half and at offset 15 as the low half. At offset 15 done pulses and the read data holds {high, low}.
- R7: On a read, the nibble output enable returns high at offset 19.
- R8: A request raised while a transfer is in progress is ignored. The running transfer completes with its own data, and no second transfer starts afterwards.
- R9: A probe request while idle raises chip select, sets the direction line low and drives register address 3 on the nibble output.
- R10: A probe ends successfully when acknowledge rises and then falls before the poll limit. Done pulses with error low, and chip select is released.
- R11: If acknowledge never rises during a probe, done and error pulse together on the 256th clock edge after the probe is accepted, and chip select is released.
- R12: If acknowledge rises during a probe but does not fall before the shared 256-poll counter runs out, done and error pulse together.
- R13: Done is high for exactly one clock per operation, and error is only ever high together with done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a byte transfer (sampled when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 4 | Subprocessor register address |
| reqWdata | input | 8 | Byte to write |
| probeStart | input | 1 | Start presence detect (request has priority) |
| rspRdata | output | 8 | Byte read |
| rspDone | output | 1 | One-clock completion pulse |
| rspError | output | 1 | Presence-detect timeout, with done |
| pinCs | output | 1 | Chip select, active high |
| pinRw | output | 1 | Direction line, high = read |
| pinAck | input | 1 | Acknowledge from subprocessor (asynchronous) |
| nibOut | output | 4 | Nibble bus output value |
| nibOe | output | 1 | Nibble bus output enable |
| nibIn | input | 4 | Nibble bus input value |

## Verification
A wrong offset counter or a wrong state shows up directly at the pins. The nibble output changes, or the output enable or chip select moves, a clock early or late relative to the acknowledge edge. A wrongly latched half-byte shows in the read data at the done pulse of the same transfer. A broken probe counter shows as a missing or early error pulse, exactly at the 256-edge boundary. A busy filter that admits a second request shows within one clock as chip select rising again after completion.

// File: rtl/nib_link_pkg.sv
package nib_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_XFER,
    ST_PROBE_HI,
    ST_PROBE_LO
  } linkState_t;

  // strobes from control to datapath, each acts on the next clock edge
  typedef struct packed {
    logic loadReq;
    logic selProbe;
    logic csClr;
    logic driveHi;
    logic driveLo;
    logic oeOff;
    logic oeOn;
    logic capHi;
    logic capLo;
    logic done;
    logic error;
  } ctlStrobes_t;

endpackage

// File: rtl/nib_link_sync.sv
module nib_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              lvlQ;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lvlQ <= 1'b0;
    else       lvlQ <= chain[STAGES-1];

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~lvlQ;
endmodule

// File: rtl/nib_link_ctrl.sv
module nib_link_ctrl
  import nib_link_pkg::*;
#(
  parameter int TURN_OFS    = 4,
  parameter int WLOW_OFS    = 9,
  parameter int RHI_OFS     = 10,
  parameter int RLO_OFS     = 15,
  parameter int RESTORE_OFS = 19,
  parameter int POLL_LIMIT  = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        probeStart,
  input  logic        ackLvl,
  input  logic        ackRise,
  output ctlStrobes_t stb
);
  localparam int SPAN  = (POLL_LIMIT > RESTORE_OFS + 1) ? POLL_LIMIT : RESTORE_OFS + 1;
  localparam int CNT_W = $clog2(SPAN) + 1;

  linkState_t       state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             xferWrite, xferWriteNx;
  logic             pollEnd;

  assign pollEnd = (cnt == CNT_W'(POLL_LIMIT - 1));

  always_comb begin
    stb         = '0;
    stateNx     = state;
    cntNx       = cnt;
    xferWriteNx = xferWrite;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.loadReq = 1'b1;
          xferWriteNx = reqWrite;
          stateNx     = ST_SELECT;
        end else if (probeStart) begin
          stb.selProbe = 1'b1;
          cntNx        = '0;
          stateNx      = ST_PROBE_HI;
        end
      end
      ST_SELECT: begin
        if (ackRise) begin
          cntNx   = '0;
          stateNx = ST_XFER;
        end
      end
      ST_XFER: begin
        cntNx = cnt + CNT_W'(1);
        if (cnt == CNT_W'(TURN_OFS)) begin
          stb.driveHi = xferWrite;
          stb.oeOff   = ~xferWrite;
        end
        if (cnt == CNT_W'(TURN_OFS + 1)) stb.csClr = 1'b1;
        if (xferWrite) begin
          if (cnt == CNT_W'(WLOW_OFS)) begin
            stb.driveLo = 1'b1;
            stb.done    = 1'b1;
            stateNx     = ST_IDLE;
          end
        end else begin
          if (cnt == CNT_W'(RHI_OFS)) stb.capHi = 1'b1;
          if (cnt == CNT_W'(RLO_OFS)) begin
            stb.capLo = 1'b1;
            stb.done  = 1'b1;
          end
          if (cnt == CNT_W'(RESTORE_OFS)) begin
            stb.oeOn = 1'b1;
            stateNx  = ST_IDLE;
          end
        end
      end
      ST_PROBE_HI: begin
        if (ackLvl) begin
          cntNx   = cnt + CNT_W'(1);
          stateNx = ST_PROBE_LO;
        end else if (pollEnd) begin
          stb.csClr = 1'b1;
          stb.done  = 1'b1;
          stb.error = 1'b1;
          stateNx   = ST_IDLE;
        end else begin
          cntNx = cnt + CNT_W'(1);
        end
      end
      ST_PROBE_LO: begin
        if (!ackLvl) begin
          stb.csClr = 1'b1;
          stb.done  = 1'b1;
          stateNx   = ST_IDLE;
        end else if (pollEnd) begin
          stb.csClr = 1'b1;
          stb.done  = 1'b1;
          stb.error = 1'b1;
          stateNx   = ST_IDLE;
        end else begin
          cntNx = cnt + CNT_W'(1);
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      xferWrite <= 1'b0;
    end else begin
      state     <= stateNx;
      cnt       <= cntNx;
      xferWrite <= xferWriteNx;
    end
  end
endmodule

// File: rtl/nib_link_dp.sv
module nib_link_dp
  import nib_link_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int PROBE_ADDR = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        stb,
  input  logic               reqWrite,
  input  logic [NIB_W-1:0]   reqAddr,
  input  logic [2*NIB_W-1:0] reqWdata,
  input  logic [NIB_W-1:0]   nibIn,
  output logic [NIB_W-1:0]   nibOut,
  output logic               nibOe,
  output logic               pinCs,
  output logic               pinRw,
  output logic [2*NIB_W-1:0] rspRdata,
  output logic               rspDone,
  output logic               rspError
);
  logic [2*NIB_W-1:0] wdataQ;
  logic [NIB_W-1:0]   rdHiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdataQ   <= '0;
      rdHiQ    <= '0;
      nibOut   <= '0;
      nibOe    <= 1'b1;
      pinCs    <= 1'b0;
      pinRw    <= 1'b1;
      rspRdata <= '0;
      rspDone  <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspDone  <= stb.done;
      rspError <= stb.error;
      if (stb.loadReq) begin
        wdataQ <= reqWdata;
        nibOut <= reqAddr;
        pinCs  <= 1'b1;
        pinRw  <= ~reqWrite;
      end
      if (stb.selProbe) begin
        nibOut <= NIB_W'(PROBE_ADDR);
        pinCs  <= 1'b1;
        pinRw  <= 1'b0;
      end
      if (stb.csClr)   pinCs  <= 1'b0;
      if (stb.driveHi) nibOut <= wdataQ[2*NIB_W-1:NIB_W];
      if (stb.driveLo) nibOut <= wdataQ[NIB_W-1:0];
      if (stb.oeOff)   nibOe  <= 1'b0;
      if (stb.oeOn)    nibOe  <= 1'b1;
      if (stb.capHi)   rdHiQ  <= nibIn;
      if (stb.capLo)   rspRdata <= {rdHiQ, nibIn};
    end
  end
endmodule

// File: rtl/nib_link_master.sv
module nib_link_master
  import nib_link_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TURN_OFS    = 4,
  parameter int WLOW_OFS    = 9,
  parameter int RHI_OFS     = 10,
  parameter int RLO_OFS     = 15,
  parameter int RESTORE_OFS = 19,
  parameter int POLL_LIMIT  = 256,
  parameter int PROBE_ADDR  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [NIB_W-1:0]   reqAddr,
  input  logic [2*NIB_W-1:0] reqWdata,
  input  logic               probeStart,
  output logic [2*NIB_W-1:0] rspRdata,
  output logic               rspDone,
  output logic               rspError,
  output logic               pinCs,
  output logic               pinRw,
  input  logic               pinAck,
  output logic [NIB_W-1:0]   nibOut,
  output logic               nibOe,
  input  logic [NIB_W-1:0]   nibIn
);
  ctlStrobes_t stb;
  logic        ackLvl, ackRise;

  nib_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinAck), .lvl(ackLvl), .rise(ackRise)
  );

  nib_link_ctrl #(
    .TURN_OFS(TURN_OFS), .WLOW_OFS(WLOW_OFS), .RHI_OFS(RHI_OFS),
    .RLO_OFS(RLO_OFS), .RESTORE_OFS(RESTORE_OFS), .POLL_LIMIT(POLL_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .probeStart(probeStart), .ackLvl(ackLvl), .ackRise(ackRise), .stb(stb)
  );

  nib_link_dp #(.NIB_W(NIB_W), .PROBE_ADDR(PROBE_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .nibIn(nibIn), .nibOut(nibOut), .nibOe(nibOe),
    .pinCs(pinCs), .pinRw(pinRw), .rspRdata(rspRdata), .rspDone(rspDone),
    .rspError(rspError)
  );
endmodule

// File: rtl/nib_link_master_chk.sv
module nib_link_master_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             rspDone,
  input logic             rspError,
  input logic             pinCs,
  input logic             pinRw,
  input logic             nibOe,
  input logic [NIB_W-1:0] nibOut
);
  // R13: done lasts one clock
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R11 / R13: error only alongside done
  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspDone);

  // R5: bus only turned around for reads
  p_oe_read_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    !nibOe |-> pinRw);

  // R2: direction line steady while selected
  p_rw_steady_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pinCs && $past(pinCs)) |-> $stable(pinRw));

  // R2: read address held on the bus while selected
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pinCs && $past(pinCs) && pinRw) |-> $stable(nibOut));
endmodule

bind nib_link_master nib_link_master_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rstN(rstN), .rspDone(rspDone), .rspError(rspError),
  .pinCs(pinCs), .pinRw(pinRw), .nibOe(nibOe), .nibOut(nibOut)
);

// File: tb/nib_link_master_tb.sv
`timescale 1ns/1ps
module nib_link_master_tb;
  localparam int TURN = 4, WLOW = 9, RHI = 10, RLO = 15, RESTORE = 19, LIMIT = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0, probeStart = 1'b0, pinAck = 1'b0;
  logic [3:0] reqAddr = '0, nibIn = '0;
  logic [7:0] reqWdata = '0;
  logic [7:0] rspRdata;
  logic       rspDone, rspError, pinCs, pinRw, nibOe;
  logic [3:0] nibOut;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nib_link_master u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .probeStart(probeStart),
    .rspRdata(rspRdata), .rspDone(rspDone), .rspError(rspError),
    .pinCs(pinCs), .pinRw(pinRw), .pinAck(pinAck), .nibOut(nibOut),
    .nibOe(nibOe), .nibIn(nibIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(input bit w, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(pinCs == 1'b1, "R2 cs", pinCs, 1);
    check(pinRw == !w, "R2 rw", pinRw, !w);
    check(nibOut == a, "R2 addr", nibOut, a);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    pinAck = 1'b1;
    for (int j = 1; j <= 4 + WLOW; j++) begin
      tick();
      if (j == 4 + TURN) begin
        check(nibOut == d[7:4], "R3 high nibble", nibOut, d[7:4]);
        check(pinCs == 1'b1, "R3 cs held", pinCs, 1);
      end
      if (j == 4 + TURN + 1) check(pinCs == 1'b0, "R3 cs release", pinCs, 0);
      if (j == 4 + WLOW - 1) check(rspDone == 1'b0, "R4 done early", rspDone, 0);
      if (j == 4 + WLOW) begin
        check(nibOut == d[3:0], "R4 low nibble", nibOut, d[3:0]);
        check(rspDone && !rspError, "R4 done", {rspDone, rspError}, 2);
      end
    end
    tick();
    check(rspDone == 1'b0, "R13 done width", rspDone, 0);
    pinAck = 1'b0;
    repeat (4) tick();
  endtask

  task automatic doRead(input logic [3:0] a, input logic [3:0] hi, input logic [3:0] lo,
                        input bit intrude);
    issue(1'b0, a, 8'h00);
    pinAck = 1'b1;
    nibIn  = hi;
    for (int j = 1; j <= 4 + RESTORE; j++) begin
      tick();
      if (intrude && j == 6) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ~a; reqWdata = 8'h5A;
      end
      if (intrude && j == 8) reqValid = 1'b0;
      if (j == 4 + TURN)     check(nibOe == 1'b0, "R5 oe off", nibOe, 0);
      if (j == 4 + TURN - 1) check(nibOe == 1'b1, "R5 oe early", nibOe, 1);
      if (j == 4 + TURN + 1) check(pinCs == 1'b0, "R5 cs release", pinCs, 0);
      if (j == 4 + RHI) nibIn = lo;
      if (j == 4 + RLO) begin
        check(rspDone == 1'b1, "R6 done", rspDone, 1);
        check(rspRdata == expByte(hi, lo), "R6 rdata", rspRdata, expByte(hi, lo));
      end
      if (j == 4 + RLO + 1) check(rspDone == 1'b0, "R13 done width", rspDone, 0);
      if (j == 4 + RESTORE - 1) check(nibOe == 1'b0, "R7 oe early", nibOe, 0);
      if (j == 4 + RESTORE)     check(nibOe == 1'b1, "R7 oe back", nibOe, 1);
    end
    pinAck = 1'b0;
    if (intrude) begin
      for (int k = 0; k < 6; k++) begin
        tick();
        check(pinCs == 1'b0, "R8 no second transfer", pinCs, 0);
      end
    end
    repeat (4) tick();
  endtask

  task automatic probeStartSeq();
    @(negedge clk);
    probeStart = 1'b1;
    @(negedge clk);
    probeStart = 1'b0;
    check(pinCs == 1'b1, "R9 cs", pinCs, 1);
    check(pinRw == 1'b0, "R9 rw", pinRw, 0);
    check(nibOut == 4'd3, "R9 addr", nibOut, 3);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [7:0] tmp;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pinCs == 1'b0, "R1 cs", pinCs, 0);
    check(pinRw == 1'b1, "R1 rw", pinRw, 1);
    check(nibOe == 1'b1, "R1 oe", nibOe, 1);
    check(nibOut == 4'h0, "R1 nibOut", nibOut, 0);
    check(!rspDone && !rspError, "R1 done/error", {rspDone, rspError}, 0);
    rstN = 1'b1;
    repeat (2) tick();

    // directed corners
    doWrite(4'hF, 8'hFF);
    doWrite(4'h0, 8'h00);
    doRead(4'h6, 4'hA, 4'h5, 1'b0);
    doRead(4'h9, 4'h0, 4'hF, 1'b1);  // R8 intruding request

    // random mix
    for (int n = 0; n < 20; n++) begin
      tmp = 8'($urandom);
      if ($urandom % 2) doWrite(4'($urandom), tmp);
      else doRead(4'($urandom), tmp[7:4], tmp[3:0], 1'($urandom % 2));
    end

    // R10 probe success
    probeStartSeq();
    pinAck = 1'b1;
    repeat (8) tick();
    pinAck = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (rspDone) begin
        seen = 1'b1;
        check(!rspError, "R10 no error", rspError, 0);
        check(pinCs == 1'b0, "R10 cs release", pinCs, 0);
      end
    end
    check(seen, "R10 done seen", seen, 1);

    // R11 probe with no acknowledge
    probeStartSeq();
    for (int j = 2; j <= LIMIT + 1; j++) begin
      tick();
      if (j == LIMIT) check(rspDone == 1'b0, "R11 early", rspDone, 0);
      if (j == LIMIT + 1) begin
        check(rspDone && rspError, "R11 timeout", {rspDone, rspError}, 3);
        check(pinCs == 1'b0, "R11 cs release", pinCs, 0);
      end
    end
    repeat (3) tick();

    // R12 acknowledge stuck high
    probeStartSeq();
    pinAck = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < LIMIT + 10; k++) begin
      tick();
      if (rspDone && rspError) seen = 1'b1;
    end
    check(seen, "R12 stuck ack error", seen, 1);
    pinAck = 1'b0;
    repeat (4) tick();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule